// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block decides when the processor's local bus may be handed to another bus master. It samples a hold request on the rising clock edge and follows the processor's own bus activity: single transfers, multi-beat bursts and chains of locked transfers. It grants the bus only at a legal boundary. When it grants, it raises the hold acknowledge and the bus float enable in the same clock. The float enable tri-states the address, data and control pins, the lock pin and the page attribute pins. The acknowledge pin itself stays driven.

The bus cycle sequencer supplies the inputs. `cyc_start` is a one-clock pulse that begins a transfer. `rdy` marks each data beat. `burst_last` qualifies the beat that ends the transfer; a single transfer holds it high. `lock_seq` stays high while a locked chain continues and drops during the chain's final transfer. The controller produces the lock output from these. A separate test request floats every output, including the acknowledge, for board-level test.

Top module: `bus_hold_ctrl`

## Requirements
- R1: After synchronous reset, hold_ack=0, bus_float=0, bus_lock=0 and ack_oe=1.
- R2: With no transfer in progress and bus_lock low, hold_req high before rising edge k makes hold_ack high after edge k+1.
- R3: While a transfer is in progress, no grant is made before the edge that sees rdy=1 with burst_last=1. If the request is already sampled, the grant is made at that edge. A request that arrives mid-burst waits for that beat.
- R4: No grant is made while bus_lock is high or between the transfers of a locked chain. The grant comes at the edge that ends the chain's last transfer, that is, rdy=1, burst_last=1 and lock_seq=0.
- R5: bus_lock rises at the edge that samples cyc_start=1 with lock_seq=1. It falls at the edge that samples rdy=1, burst_last=1 and lock_seq=0 during a locked transfer.
- R6: Outside test mode, bus_float equals hold_ack in every clock, and hold_ack is never high together with bus_lock.
- R7: hold_ack stays high while hold_req is sampled high. It drops at the edge after the edge that samples hold_req low.
- R8: tst_req sampled high at an edge gives ack_oe=0 and bus_float=1 after that edge. Sampled low, it gives ack_oe=1.
- R9: cyc_start is ignored while hold_ack is high, and also during a transfer except on its ending beat. An ignored cyc_start neither starts a transfer nor raises bus_lock.
- R10: When cyc_start=1 arrives at the same edge where a pending grant would otherwise be made, the transfer starts and the grant waits for it to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Bus request from the external master |
| cyc_start | input | 1 | One-clock pulse starting a bus transfer |
| rdy | input | 1 | Data beat completed |
| burst_last | input | 1 | Qualifies the beat that ends the transfer |
| lock_seq | input | 1 | Locked chain active; low during its final transfer |
| tst_req | input | 1 | Test request: float every output |
| hold_ack | output | 1 | Hold acknowledge |
| ack_oe | output | 1 | Output enable for hold_ack |
| bus_float | output | 1 | Float enable for address, data, control, lock and page attribute pins |
| bus_lock | output | 1 | Bus lock, active high |

## Verification
The embedded assertions check the clock-by-clock invariants: acknowledge never coexists with lock, float always accompanies acknowledge, hold persists while requested, no grant is made in the middle of a transfer, and lock clears after the chain's final beat. Grant latency, the deferral behind a chain of locked transfers, the precedence of a same-edge transfer start, and the proof that ignored starts leave no trace can only be seen in the bench's sequenced scenarios. In those scenarios a behavioural reference model predicts all four outputs on every clock.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic {
    ST_OWN  = 1'b0,
    ST_HOLD = 1'b1
  } hold_st_e;
endpackage

// File: rtl/hold_sampler.sv
// Rising-edge sampler chain for a synchronous level input.
module hold_sampler #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_nxt
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
      assign q_nxt = d;
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
      assign q_nxt = sh[STAGES-2];
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cycle_tracker.sv
// Tracks the processor's own bus activity and the lock output.
module cycle_tracker (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic rdy,
  input  logic burst_last,
  input  logic lock_seq,
  input  logic in_hold,
  output logic busy,
  output logic lock,
  output logic bus_free,
  output logic lock_free
);
  logic cyc_end, start_ok;

  assign cyc_end   = busy && rdy && burst_last;
  assign bus_free  = !busy || cyc_end;
  assign lock_free = !lock || (cyc_end && !lock_seq);
  assign start_ok  = cyc_start && !in_hold && bus_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      lock <= 1'b0;
    end else begin
      if (start_ok)     busy <= 1'b1;
      else if (cyc_end) busy <= 1'b0;

      if (start_ok && lock_seq)     lock <= 1'b1;
      else if (cyc_end && !lock_seq) lock <= 1'b0;
    end
  end

  // R5: the final beat of a locked chain clears lock on the next clock
  a_r5_lock_drop: assert property (@(posedge clk) disable iff (rst)
    (lock && busy && rdy && burst_last && !lock_seq && !cyc_start) |=> !lock);

  // R9: while the bus is held, no transfer is tracked
  a_r9_idle_in_hold: assert property (@(posedge clk) disable iff (rst)
    in_hold |-> !busy);
endmodule

// File: rtl/hold_fsm.sv
// Grant / release state machine.
module hold_fsm
  import hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hold_q,
  input  logic     cyc_start,
  input  logic     bus_free,
  input  logic     lock_free,
  output hold_st_e st,
  output logic     hold_nxt
);
  logic grant, release_now;

  assign grant       = (st == ST_OWN) && hold_q && bus_free && lock_free && !cyc_start;
  assign release_now = (st == ST_HOLD) && !hold_q;

  always_comb begin
    hold_nxt = (st == ST_HOLD);
    if (grant)       hold_nxt = 1'b1;
    if (release_now) hold_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_OWN;
    else     st <= hold_nxt ? ST_HOLD : ST_OWN;
  end

  // R3: no grant while the bus is not at a boundary
  a_r3_wait_boundary: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OWN && !bus_free) |=> (st == ST_OWN));

  // R7: hold persists while the sampled request stays high
  a_r7_stay_in_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && hold_q) |=> (st == ST_HOLD));
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import hold_pkg::*;
#(
  parameter int SAMPLE_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic cyc_start,
  input  logic rdy,
  input  logic burst_last,
  input  logic lock_seq,
  input  logic tst_req,
  output logic hold_ack,
  output logic ack_oe,
  output logic bus_float,
  output logic bus_lock
);
  logic     hold_q, hold_q_nxt_unused;
  logic     tst_q_unused, tst_nxt;
  logic     busy, lock, bus_free, lock_free, hold_nxt;
  hold_st_e st;

  hold_sampler #(.STAGES(SAMPLE_STAGES)) u_hold_smp (
    .clk(clk), .rst(rst), .d(hold_req), .q(hold_q), .q_nxt(hold_q_nxt_unused)
  );

  hold_sampler #(.STAGES(SAMPLE_STAGES)) u_tst_smp (
    .clk(clk), .rst(rst), .d(tst_req), .q(tst_q_unused), .q_nxt(tst_nxt)
  );

  cycle_tracker u_trk (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .rdy(rdy),
    .burst_last(burst_last), .lock_seq(lock_seq), .in_hold(st == ST_HOLD),
    .busy(busy), .lock(lock), .bus_free(bus_free), .lock_free(lock_free)
  );

  hold_fsm u_fsm (
    .clk(clk), .rst(rst), .hold_q(hold_q), .cyc_start(cyc_start),
    .bus_free(bus_free), .lock_free(lock_free), .st(st), .hold_nxt(hold_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_float <= 1'b0;
      ack_oe    <= 1'b1;
    end else begin
      bus_float <= hold_nxt || tst_nxt;
      ack_oe    <= !tst_nxt;
    end
  end

  assign hold_ack = (st == ST_HOLD);
  assign bus_lock = lock;

  // R4 / R6: acknowledge and lock are never high together
  a_r4_no_ack_with_lock: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> !bus_lock);

  // R6: the pins float whenever acknowledge is high
  a_r6_float_with_ack: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> bus_float);

  // R8: a floated acknowledge implies floated bus pins
  a_r8_oe_float: assert property (@(posedge clk) disable iff (rst)
    !ack_oe |-> bus_float);
endmodule

// File: tb/sim_bus_hold_ctrl.sv
module sim_bus_hold_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req = 0, cyc_start = 0, rdy = 0, burst_last = 0, lock_seq = 0, tst_req = 0;
  logic hold_ack, ack_oe, bus_float, bus_lock;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_hold_ctrl u0 (
    .clk(clk), .rst(rst), .hold_req(hold_req), .cyc_start(cyc_start), .rdy(rdy),
    .burst_last(burst_last), .lock_seq(lock_seq), .tst_req(tst_req),
    .hold_ack(hold_ack), .ack_oe(ack_oe), .bus_float(bus_float), .bus_lock(bus_lock)
  );

  // Behavioural reference model, updated at each rising edge
  bit m_hq, m_tq, m_busy, m_lock, m_hold;
  always @(posedge clk) begin
    bit fin, idle, lfree, grant, start;
    if (rst) begin
      m_hq = 0; m_tq = 0; m_busy = 0; m_lock = 0; m_hold = 0;
    end else begin
      fin   = m_busy && rdy && burst_last;
      idle  = !m_busy || fin;
      lfree = !m_lock || (fin && !lock_seq);
      grant = !m_hold && m_hq && idle && lfree && !cyc_start;
      start = cyc_start && !m_hold && idle;
      if (start) begin
        m_busy = 1;
        if (lock_seq) m_lock = 1;
        else if (fin) m_lock = 0;
      end else if (fin) begin
        m_busy = 0;
        if (!lock_seq) m_lock = 0;
      end
      if (grant) m_hold = 1;
      else if (m_hold && !m_hq) m_hold = 0;
      m_hq = hold_req;
      m_tq = tst_req;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R3/R4/R7 hold_ack model", hold_ack, m_hold);
      chk("R5 bus_lock model", bus_lock, m_lock);
      chk("R6/R8 bus_float model", bus_float, m_hold | m_tq);
      chk("R8 ack_oe model", ack_oe, !m_tq);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drop_hold();
    hold_req = 0; step(2);
    chk("R7 ack released", hold_ack, 1'b0);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    chk("R1 hold_ack reset", hold_ack, 1'b0);
    chk("R1 bus_float reset", bus_float, 1'b0);
    chk("R1 bus_lock reset", bus_lock, 1'b0);
    chk("R1 ack_oe reset", ack_oe, 1'b1);

    // R2: idle grant latency
    hold_req = 1; step(1);
    chk("R2 ack not yet", hold_ack, 1'b0);
    step(1);
    chk("R2 ack granted", hold_ack, 1'b1);
    chk("R6 float with ack", bus_float, 1'b1);
    step(3);
    hold_req = 0; step(1);
    chk("R7 ack held one more clock", hold_ack, 1'b1);
    step(1);
    chk("R7 ack dropped", hold_ack, 1'b0);
    chk("R6 float dropped", bus_float, 1'b0);

    // R3: single transfer
    cyc_start = 1; burst_last = 1; step(1);
    cyc_start = 0; hold_req = 1; step(2);
    chk("R3 no grant during single", hold_ack, 1'b0);
    rdy = 1; step(1);
    chk("R3 grant at single end", hold_ack, 1'b1);
    rdy = 0; burst_last = 0;
    drop_hold();

    // R3 + R9: burst with a request mid-burst and a stray start
    cyc_start = 1; step(1);
    cyc_start = 0; hold_req = 1; rdy = 1;
    cyc_start = 1; lock_seq = 1; step(1);
    chk("R9 stray start mid-burst no lock", bus_lock, 1'b0);
    cyc_start = 0; lock_seq = 0; step(2);
    chk("R3 no grant mid-burst", hold_ack, 1'b0);
    burst_last = 1; step(1);
    chk("R3 grant at burst end", hold_ack, 1'b1);
    rdy = 0; burst_last = 0;
    drop_hold();

    // R4 + R5: two-transfer locked chain
    cyc_start = 1; lock_seq = 1; burst_last = 1; step(1);
    chk("R5 lock rises", bus_lock, 1'b1);
    cyc_start = 0; rdy = 1; step(1);
    chk("R5 lock held between transfers", bus_lock, 1'b1);
    rdy = 0; hold_req = 1; step(3);
    chk("R4 no grant inside chain", hold_ack, 1'b0);
    cyc_start = 1; step(1);
    cyc_start = 0; rdy = 1; lock_seq = 0; step(1);
    chk("R5 lock falls", bus_lock, 1'b0);
    chk("R4 grant at chain end", hold_ack, 1'b1);
    rdy = 0; burst_last = 0;
    drop_hold();

    // R9: start ignored while in hold
    hold_req = 1; step(2);
    chk("R9 in hold", hold_ack, 1'b1);
    cyc_start = 1; lock_seq = 1; burst_last = 1; step(1);
    cyc_start = 0; lock_seq = 0;
    chk("R9 no lock from ignored start", bus_lock, 1'b0);
    drop_hold();
    hold_req = 1; step(2);
    chk("R9 no phantom transfer", hold_ack, 1'b1);
    drop_hold();

    // R10: same-edge start beats a pending grant
    hold_req = 1; step(1);
    cyc_start = 1; step(1);
    chk("R10 grant deferred", hold_ack, 1'b0);
    cyc_start = 0; rdy = 1; step(1);
    chk("R10 grant after transfer", hold_ack, 1'b1);
    rdy = 0; burst_last = 0;
    drop_hold();

    // R8: three-state test
    tst_req = 1; step(1);
    chk("R8 ack_oe low", ack_oe, 1'b0);
    chk("R8 float high", bus_float, 1'b1);
    tst_req = 0; step(1);
    chk("R8 ack_oe restored", ack_oe, 1'b1);
    chk("R8 float restored", bus_float, 1'b0);

    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule